// File: doc/BRIEF.md
# Speculative Multi-Operand Decimal Adder

This block adds a fixed set of unsigned packed-decimal operands in one pass and returns their canonical decimal total. Each operand holds `DIGITS` four-bit decimal digits. The number of operands, `N_OPS`, may be set from 4 to 16. The result gains enough extra digits that the total never overflows, even when every operand is all nines.

The operands pass through a chain of digit-wide carry-save steps. Each step assumes its digit total will not exceed nine. The +6 decimal correction is added in a later step, and the binary carry-out of an earlier step decides whether it is needed. This removes any per-digit compare against nine from the chain. The first step adds the first two operands with no correction. With `DOUBLE_SPEC` set, the correction applied at each step comes from the carry-out of two steps earlier, which takes the 0/6 select off the step's critical input.

A closing normalisation stage folds in every correction and carry still pending and ripples the decimal carries. When `REG_OUT` is 1 the result is registered, and `out_valid` follows `in_valid` by one clock.

Top module: `bcd_multi_adder`

## Requirements
- R1: When `out_valid` is high, `sum_o` equals the decimal sum of all `N_OPS` operands. Each 4-bit digit of `sum_o` (digit i at bits 4i+3..4i, least significant first) lies in 0..9.
- R2: `sum_o` has `DIGITS` + ceil(log10(`N_OPS`)) digits. With every operand digit at 9, the result is exactly `N_OPS` × (10^`DIGITS` − 1) and does not overflow.
- R3: With `REG_OUT`=1, `out_valid` is high in the cycle after each cycle where `in_valid` was high, and low in the cycle after each cycle where it was low. The matching sum is presented with it.
- R4: While `rst` is high, at the next clock edge `out_valid` goes to 0 and `sum_o` goes to all zeros.
- R5: A cycle with `in_valid` low leaves `sum_o` unchanged.
- R6: The single-step and two-step speculation variants (`DOUBLE_SPEC` 0 and 1) give identical results for every operand set.
- R7: A decimal carry that ripples through every result digit (e.g. 9999 + 0001) is resolved correctly.
- R8: The result is correct when the first two operands' digit totals exceed nine, which means the first step guessed wrong.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set on `operands_i` is valid this cycle |
| operands_i | input | N_OPS*DIGITS*4 | Packed operands, operand k at bits [k*DIGITS*4 +: DIGITS*4] |
| out_valid | output | 1 | `sum_o` holds a fresh result |
| sum_o | output | (DIGITS+ceil(log10(N_OPS)))*4 | Canonical decimal total |

## Verification
The bench uses the all-nines set to reach the widest total, so a design with too narrow a result, or one that dropped the top step's carry, would lose the leading digit. It includes sets where the first two operands overflow every digit. A design that forgot a pending +6 would leave digits at 10..15 or short the total by six per column. A long 9999 + 0001 ripple exercises the closing carry chain, where a broken chain would leave 9s or zeros behind. A second instance with two-step speculation is compared on every result, since using the wrong lag for the correction would shift or lose corrections. Gaps between inputs show whether the registered result is held or overwritten by stale logic.

// File: rtl/bcd_madd_pkg.sv
package bcd_madd_pkg;

  // number of decimal digits needed to hold a count n (smallest r with 10^r >= n)
  function automatic int clog10(input int n);
    int      r;
    longint  p;
    r = 0;
    p = 1;
    while (p < longint'(n)) begin
      p = p * 10;
      r = r + 1;
    end
    return r;
  endfunction

  typedef logic [3:0] digit_t;

  localparam digit_t DEC_FIX = 4'd6;

endpackage

// File: rtl/bcd_csa_step.sv
// One digit-wide carry-save step of the speculative chain.
// Per digit the state is: s (4-bit residue), p1/p2 (pending +6 from one / two
// steps back) and k (pending carry into this digit). Value of a digit column is
// s + 6*(p1+p2) + k, and every term is non-negative.
module bcd_csa_step
  import bcd_madd_pkg::*;
#(
  parameter int NDIG        = 5,
  parameter bit DOUBLE_SPEC = 1'b0
) (
  input  logic [NDIG*4-1:0] s_i,
  input  logic [NDIG-1:0]   p1_i,
  input  logic [NDIG-1:0]   p2_i,
  input  logic [NDIG-1:0]   k_i,
  input  logic [NDIG*4-1:0] b_i,
  output logic [NDIG*4-1:0] s_o,
  output logic [NDIG-1:0]   p1_o,
  output logic [NDIG-1:0]   p2_o,
  output logic [NDIG-1:0]   k_o
);

  logic [NDIG-1:0] cout;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic       use_fix;
    logic [4:0] tot;

    if (DOUBLE_SPEC) begin : g_two
      // correction from two steps back is already settled when this step starts
      assign use_fix = p2_i[d];
      assign p2_o[d] = p1_i[d];
    end else begin : g_one
      assign use_fix = p1_i[d];
      assign p2_o[d] = 1'b0;
    end

    assign tot      = {1'b0, s_i[4*d +: 4]} + {1'b0, b_i[4*d +: 4]}
                    + (use_fix ? {1'b0, DEC_FIX} : 5'd0) + {4'd0, k_i[d]};
    assign s_o[4*d +: 4] = tot[3:0];
    assign cout[d]  = tot[4];
    // a binary carry of 16 is one decimal ten plus six owed to this digit
    assign p1_o[d]  = tot[4];
  end

  // top digit never carries: its column value stays below ten by width choice
  if (NDIG > 1) begin : g_kshift
    assign k_o = {cout[NDIG-2:0], 1'b0};
  end else begin : g_kone
    assign k_o = 1'b0;
  end

endmodule

// File: rtl/bcd_final_norm.sv
// Folds pending corrections and carries into canonical decimal digits.
module bcd_final_norm
  import bcd_madd_pkg::*;
#(
  parameter int NDIG = 5
) (
  input  logic [NDIG*4-1:0] s_i,
  input  logic [NDIG-1:0]   p1_i,
  input  logic [NDIG-1:0]   p2_i,
  input  logic [NDIG-1:0]   k_i,
  output logic [NDIG*4-1:0] sum_o
);

  logic [1:0] cy [NDIG+1];

  assign cy[0] = 2'd0;

  for (genvar d = 0; d < NDIG; d++) begin : g_dig
    logic [5:0] col;
    logic [5:0] adj;

    // column total: residue + owed corrections + carries (at most 31)
    assign col = {2'b0, s_i[4*d +: 4]}
               + (p1_i[d] ? 6'd6 : 6'd0) + (p2_i[d] ? 6'd6 : 6'd0)
               + {5'd0, k_i[d]} + {4'd0, cy[d]};

    always_comb begin
      if (col >= 6'd30) begin
        cy[d+1] = 2'd3;
        adj     = col - 6'd30;
      end else if (col >= 6'd20) begin
        cy[d+1] = 2'd2;
        adj     = col - 6'd20;
      end else if (col >= 6'd10) begin
        cy[d+1] = 2'd1;
        adj     = col - 6'd10;
      end else begin
        cy[d+1] = 2'd0;
        adj     = col;
      end
    end

    assign sum_o[4*d +: 4] = adj[3:0];
  end

endmodule

// File: rtl/bcd_multi_adder.sv
module bcd_multi_adder
  import bcd_madd_pkg::*;
#(
  parameter  int N_OPS       = 8,
  parameter  int DIGITS      = 4,
  parameter  bit DOUBLE_SPEC = 1'b0,
  parameter  bit REG_OUT     = 1'b1,
  localparam int EXT         = clog10(N_OPS),
  localparam int RW          = DIGITS + EXT,
  localparam int OPW         = DIGITS * 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  in_valid,
  input  logic [N_OPS*OPW-1:0]  operands_i,
  output logic                  out_valid,
  output logic [RW*4-1:0]       sum_o
);

  // chain state after each operand has been absorbed
  logic [RW*4-1:0] st_s  [N_OPS];
  logic [RW-1:0]   st_p1 [N_OPS];
  logic [RW-1:0]   st_p2 [N_OPS];
  logic [RW-1:0]   st_k  [N_OPS];
  logic [RW*4-1:0] ext_op [N_OPS];
  logic [RW*4-1:0] norm_sum;

  for (genvar j = 0; j < N_OPS; j++) begin : g_ext
    assign ext_op[j] = {{(EXT*4){1'b0}}, operands_i[j*OPW +: OPW]};
  end

  // seed: operand 0 with nothing pending, so step 1 adds a zero correction
  assign st_s[0]  = ext_op[0];
  assign st_p1[0] = '0;
  assign st_p2[0] = '0;
  assign st_k[0]  = '0;

  for (genvar j = 1; j < N_OPS; j++) begin : g_chain
    bcd_csa_step #(
      .NDIG        (RW),
      .DOUBLE_SPEC (DOUBLE_SPEC)
    ) u_step (
      .s_i  (st_s[j-1]),
      .p1_i (st_p1[j-1]),
      .p2_i (st_p2[j-1]),
      .k_i  (st_k[j-1]),
      .b_i  (ext_op[j]),
      .s_o  (st_s[j]),
      .p1_o (st_p1[j]),
      .p2_o (st_p2[j]),
      .k_o  (st_k[j])
    );
  end

  bcd_final_norm #(
    .NDIG (RW)
  ) u_norm (
    .s_i   (st_s[N_OPS-1]),
    .p1_i  (st_p1[N_OPS-1]),
    .p2_i  (st_p2[N_OPS-1]),
    .k_i   (st_k[N_OPS-1]),
    .sum_o (norm_sum)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        out_valid <= 1'b0;
        sum_o     <= '0;
      end else begin
        out_valid <= in_valid;
        if (in_valid) sum_o <= norm_sum;
      end
    end
  end else begin : g_comb
    assign out_valid = in_valid;
    assign sum_o     = norm_sum;
  end

endmodule

// File: rtl/bcd_multi_adder_chk.sv
module bcd_multi_adder_chk #(
  parameter int N_OPS   = 8,
  parameter bit REG_OUT = 1'b1,
  parameter int RW      = 5
) (
  input logic            clk,
  input logic            rst,
  input logic            in_valid,
  input logic            out_valid,
  input logic [RW*4-1:0] sum_o
);

  function automatic logic digits_ok(input logic [RW*4-1:0] v);
    for (int i = 0; i < RW; i++)
      if (v[4*i +: 4] > 4'd9) return 1'b0;
    return 1'b1;
  endfunction

  initial begin
    a_r2_op_range : assert (N_OPS >= 4 && N_OPS <= 16);
  end

  if (REG_OUT) begin : g_seq
    // R4
    a_r4_reset_clear : assert property (@(posedge clk)
      rst |=> (!out_valid && sum_o == '0));
    // R3
    a_r3_valid_follows : assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    // R3
    a_r3_idle_quiet : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);
    // R5
    a_r5_hold_sum : assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(sum_o));
    // R1
    a_r1_digits_decimal : assert property (@(posedge clk) disable iff (rst)
      out_valid |-> digits_ok(sum_o));
  end

endmodule

bind bcd_multi_adder bcd_multi_adder_chk #(
  .N_OPS   (N_OPS),
  .REG_OUT (REG_OUT),
  .RW      (RW)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .sum_o     (sum_o)
);

// File: tb/bcd_multi_adder_bench.sv
module bcd_multi_adder_bench;

  localparam int N   = 8;
  localparam int D   = 4;
  localparam int RW  = D + 1;
  localparam int OPW = D * 4;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                in_valid = 1'b0;
  logic [N*OPW-1:0]    ops = '0;
  logic                out_valid, out_valid_dbl;
  logic [RW*4-1:0]     sum_o, sum_dbl;

  int total = 0;
  int bad   = 0;
  logic [RW*4-1:0] exp_q [$];
  logic [RW*4-1:0] last_exp;
  bit              have_last = 0;
  bit              done = 0;

  always #5 clk = ~clk;

  bcd_multi_adder #(.N_OPS(N), .DIGITS(D), .DOUBLE_SPEC(1'b0), .REG_OUT(1'b1))
    u_bcd_multi_adder (.clk(clk), .rst(rst), .in_valid(in_valid), .operands_i(ops),
                       .out_valid(out_valid), .sum_o(sum_o));

  bcd_multi_adder #(.N_OPS(N), .DIGITS(D), .DOUBLE_SPEC(1'b1), .REG_OUT(1'b1))
    u_bcd_multi_adder_dbl (.clk(clk), .rst(rst), .in_valid(in_valid), .operands_i(ops),
                           .out_valid(out_valid_dbl), .sum_o(sum_dbl));

  function automatic longint bcd2int(input logic [63:0] v, input int nd);
    longint r = 0;
    for (int i = nd - 1; i >= 0; i--) r = r * 10 + longint'(v[4*i +: 4]);
    return r;
  endfunction

  function automatic logic [RW*4-1:0] int2bcd(input longint x);
    logic [RW*4-1:0] r = '0;
    longint t = x;
    for (int i = 0; i < RW; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: presents one operand set, queues its expected total
  task automatic send(input logic [N*OPW-1:0] v);
    longint acc = 0;
    for (int k = 0; k < N; k++) acc += bcd2int(64'(v[k*OPW +: OPW]), D);
    exp_q.push_back(int2bcd(acc));
    ops      = v;
    in_valid = 1'b1;
    @(negedge clk);
    check("R3 valid one cycle later", 64'(out_valid), 64'd1);
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [N*OPW-1:0] rand_set();
    logic [N*OPW-1:0] v;
    for (int i = 0; i < N * D; i++) v[4*i +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && !done) begin
      if (out_valid) begin
        if (exp_q.size() == 0) begin
          check("R3 unexpected result", 64'(out_valid), 64'd0);
        end else begin
          last_exp  = exp_q.pop_front();
          have_last = 1;
          check("R1 decimal total", 64'(sum_o), 64'(last_exp));
          check("R6 double speculation matches", 64'(sum_dbl), 64'(last_exp));
        end
      end else if (have_last) begin
        check("R5 held while idle", 64'(sum_o), 64'(last_exp));
      end
    end
  end

  initial begin
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N*OPW-1:0] v;
    repeat (3) @(negedge clk);
    // R4: reset state
    check("R4 reset valid", 64'(out_valid), 64'd0);
    check("R4 reset sum", 64'(sum_o), 64'd0);
    check("R4 reset dbl", 64'(sum_dbl), 64'd0);
    rst = 1'b0;
    @(negedge clk);

    // R1: all zero
    send('0);
    idle(2);

    // R2: all nines, total 8*9999 = 79992
    v = '0;
    for (int i = 0; i < N * D; i++) v[4*i +: 4] = 4'd9;
    send(v);
    idle(1);
    check("R2 all nines exact", 64'(sum_o), 64'h79992);

    // R7: 9999 + 0001 ripples to 10000
    v = '0;
    v[0 +: OPW]   = 16'h9999;
    v[OPW +: OPW] = 16'h0001;
    send(v);
    idle(1);
    check("R7 full ripple", 64'(sum_o), 64'h10000);

    // R8: first pair overflows every digit
    v = '0;
    v[0 +: OPW]       = 16'h5678;
    v[OPW +: OPW]     = 16'h8765;
    v[2*OPW +: OPW]   = 16'h0009;
    send(v);
    idle(1);
    check("R8 first step misguess", 64'(sum_o), 64'h14452);

    // R8: only late operands overflow, back to back with random sets
    v = '0;
    for (int k = 2; k < N; k++) v[k*OPW +: OPW] = 16'h7777;
    send(v);
    for (int t = 0; t < 30; t++) send(rand_set());
    idle(3);
    for (int t = 0; t < 30; t++) begin
      send(rand_set());
      idle(t % 3);
    end
    idle(3);
    check("R3 scoreboard drained", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule